// File: doc/BRIEF.md
# Graphics Interconnect Page-Change Monitor

This block watches a point-to-point link between a graphics engine and a memory controller. The link has three independent channels, each moving one unit per handshake: a read-request channel carrying an address, a read-data channel returning results, and a write channel carrying an address. The monitor never stalls the link. It only observes the valid and ready pairs and the two address buses.

Nine event counters are kept. Two count completed transfers: accepted writes and accepted read requests. Three count wait cycles, one for each channel. Three count stall episodes that run past a programmable threshold, one for each channel. One counts requests whose memory page differs from the page of the request accepted before it. The page size can be changed at run time. A small word-indexed register interface reads the counters and sets the enable, threshold and page size. It also offers a clear command and a preset command. The preset command loads each counter with its own byte offset, so software can confirm that reads are decoded to the right counter.

Top module: `gfx_page_monitor`

## Requirements
- R1: After reset every counter reads 0, the enable bit is 0, the threshold is 0 and the page-size field is 0.
- R2: Counter 0 increments on each cycle with wr_valid and wr_ready both high. Counter 1 increments on each cycle with rq_valid and rq_ready both high.
- R3: A wait cycle is a cycle with a channel's valid high and its ready low. Counter 2 counts write-channel wait cycles, counter 3 counts read-request wait cycles and counter 4 counts read-data wait cycles.
- R4: Counters 5 (read request), 6 (read data) and 7 (write) each increase by exactly one per unbroken run of wait cycles that grows longer than the threshold. The increment happens in the run's wait cycle number threshold+1. A run of exactly threshold wait cycles adds nothing.
- R5: Counter 8 increments for each accepted request whose page number differs from the stored last page. The page number is the address shifted right by 11 + page-size field, so encoding 0 gives 2 KB, 1 gives 4 KB, 2 gives 8 KB and 3 gives 16 KB pages.
- R6: Reads and writes share one last-page register. It is updated by every accepted request, even while counting is disabled. The first request after reset or clear never counts as a change. When both channels are accepted in the same cycle, the read is compared first and the write is then compared against the read's page, so one cycle can add 2.
- R7: Bit 0 of register 9 enables counting. While it is 0, no counter moves, but wait runs and the last page are still tracked.
- R8: Any write to register 12 zeroes all counters and forgets the last page. Events in that same cycle are dropped, and events in the next cycle count.
- R9: Any write to register 13 loads counter i with the value 4*i. Events in that cycle are dropped.
- R10: Register reads are combinational. Indices 0 to 8 return the counters, 9 returns the enable bit in bit 0, 10 returns the threshold, 11 returns the page-size field in bits 1:0, and 12 and 13 read as 0. A configuration write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | 1 | Read-request valid |
| rq_ready | input | 1 | Read-request ready |
| rq_addr | input | ADDR_W | Read-request address |
| rd_valid | input | 1 | Read-data valid |
| rd_ready | input | 1 | Read-data ready |
| wr_valid | input | 1 | Write valid |
| wr_ready | input | 1 | Write ready |
| wr_addr | input | ADDR_W | Write address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index for read and write |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data for reg_addr |

## Verification
The hardest states to reach from the ports are those where several rules meet in one cycle. Examples are a read and a write accepted together on different pages, a clear that coincides with traffic, and a stall run that ends exactly at the threshold rather than one cycle past it. Directed sequences place addresses on either side of 2 KB and 4 KB boundaries and hold ready low for exactly threshold and threshold+1 cycles. A long seeded random phase then draws addresses from a narrow window so that page changes and same-cycle acceptances are frequent, and injects occasional clear, preset and configuration writes in the middle of the traffic.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
    localparam int NUM_CNT   = 9;
    localparam int PAGE_BASE = 11;

    // counter indices
    localparam int CI_WR_DONE = 0;
    localparam int CI_RQ_DONE = 1;
    localparam int CI_WR_WAIT = 2;
    localparam int CI_RQ_WAIT = 3;
    localparam int CI_RD_WAIT = 4;
    localparam int CI_RQ_HIT  = 5;
    localparam int CI_RD_HIT  = 6;
    localparam int CI_WR_HIT  = 7;
    localparam int CI_PAGE    = 8;

    // register indices
    localparam int RA_CTRL   = 9;
    localparam int RA_THR    = 10;
    localparam int RA_PSIZE  = 11;
    localparam int RA_CLEAR  = 12;
    localparam int RA_PRESET = 13;

    // wait-tracker slots
    localparam int WT_RQ  = 0;
    localparam int WT_RD  = 1;
    localparam int WT_WR  = 2;
    localparam int NUM_WT = 3;

    typedef enum logic [1:0] {
        PG_2K  = 2'd0,
        PG_4K  = 2'd1,
        PG_8K  = 2'd2,
        PG_16K = 2'd3
    } pg_size_e;
endpackage

// File: rtl/gpm_wait_track.sv
module gpm_wait_track #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             hit_o
);
    localparam int RUN_W = THR_W + 1;

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } wt_state_t;

    wt_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        hit_o = stall_i && (st_q.run == {1'b0, thr_i});
        if (!stall_i) begin
            st_d.run = '0;
        end else if (st_q.run != {RUN_W{1'b1}}) begin
            st_d.run = st_q.run + RUN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gpm_page_track.sv
module gpm_page_track
    import gpm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [1:0]        psize_i,
    input  logic              rq_fire_i,
    input  logic [ADDR_W-1:0] rq_addr_i,
    input  logic              wr_fire_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [1:0]        inc_o
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] page;
    } pg_state_t;

    pg_state_t st_d, st_q;
    logic [ADDR_W-1:0] rq_page, wr_page;

    always_comb begin
        rq_page = rq_addr_i >> (PAGE_BASE + int'(psize_i));
        wr_page = wr_addr_i >> (PAGE_BASE + int'(psize_i));
        st_d    = st_q;
        inc_o   = 2'd0;
        if (flush_i) begin
            st_d.valid = 1'b0;
        end else begin
            if (rq_fire_i) begin
                if (st_d.valid && (rq_page != st_d.page)) inc_o = inc_o + 2'd1;
                st_d.page  = rq_page;
                st_d.valid = 1'b1;
            end
            if (wr_fire_i) begin
                if (st_d.valid && (wr_page != st_d.page)) inc_o = inc_o + 2'd1;
                st_d.page  = wr_page;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gfx_page_monitor.sv
module gfx_page_monitor
    import gpm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32,
    parameter int THR_W  = 8,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_valid,
    input  logic              rq_ready,
    input  logic [ADDR_W-1:0] rq_addr,
    input  logic              rd_valid,
    input  logic              rd_ready,
    input  logic              wr_valid,
    input  logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata
);
    typedef struct packed {
        logic                             en;
        logic [THR_W-1:0]                 thr;
        logic [1:0]                       psize;
        logic [NUM_CNT-1:0][CNT_W-1:0]    cnt;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic [NUM_WT-1:0]             stall;
    logic [NUM_WT-1:0]             hit;
    logic [1:0]                    page_inc;
    logic [NUM_CNT-1:0][1:0]       inc;
    logic                          do_clear, do_preset;
    logic                          rq_fire, wr_fire;
    logic                          en_q;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic                          unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign rq_fire   = rq_valid && rq_ready;
    assign wr_fire   = wr_valid && wr_ready;
    assign do_clear  = reg_we && (reg_addr == REG_AW'(RA_CLEAR));
    assign do_preset = reg_we && (reg_addr == REG_AW'(RA_PRESET));
    assign en_q      = st_q.en;
    assign cnt_q     = st_q.cnt;

    assign stall[WT_RQ] = rq_valid && !rq_ready;
    assign stall[WT_RD] = rd_valid && !rd_ready;
    assign stall[WT_WR] = wr_valid && !wr_ready;

    for (genvar g = 0; g < NUM_WT; g++) begin : g_wait
        gpm_wait_track #(.THR_W(THR_W)) u_wt (
            .clk     (clk),
            .rst_n   (rst_n),
            .stall_i (stall[g]),
            .thr_i   (st_q.thr),
            .hit_o   (hit[g])
        );
    end

    gpm_page_track #(.ADDR_W(ADDR_W)) u_pg (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (do_clear),
        .psize_i   (st_q.psize),
        .rq_fire_i (rq_fire),
        .rq_addr_i (rq_addr),
        .wr_fire_i (wr_fire),
        .wr_addr_i (wr_addr),
        .inc_o     (page_inc)
    );

    always_comb begin
        inc             = '0;
        inc[CI_WR_DONE] = {1'b0, wr_fire};
        inc[CI_RQ_DONE] = {1'b0, rq_fire};
        inc[CI_WR_WAIT] = {1'b0, stall[WT_WR]};
        inc[CI_RQ_WAIT] = {1'b0, stall[WT_RQ]};
        inc[CI_RD_WAIT] = {1'b0, stall[WT_RD]};
        inc[CI_RQ_HIT]  = {1'b0, hit[WT_RQ]};
        inc[CI_RD_HIT]  = {1'b0, hit[WT_RD]};
        inc[CI_WR_HIT]  = {1'b0, hit[WT_WR]};
        inc[CI_PAGE]    = page_inc;
    end

    always_comb begin
        st_d = st_q;
        if (do_clear) begin
            st_d.cnt = '0;
        end else if (do_preset) begin
            for (int i = 0; i < NUM_CNT; i++) st_d.cnt[i] = CNT_W'(4 * i);
        end else if (st_q.en) begin
            for (int i = 0; i < NUM_CNT; i++) st_d.cnt[i] = st_q.cnt[i] + CNT_W'(inc[i]);
        end
        if (reg_we) begin
            if (reg_addr == REG_AW'(RA_CTRL))  st_d.en    = reg_wdata[0];
            if (reg_addr == REG_AW'(RA_THR))   st_d.thr   = reg_wdata[THR_W-1:0];
            if (reg_addr == REG_AW'(RA_PSIZE)) st_d.psize = reg_wdata[1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NUM_CNT)              reg_rdata = st_q.cnt[reg_addr];
        else if (reg_addr == REG_AW'(RA_CTRL))     reg_rdata = CNT_W'(st_q.en);
        else if (reg_addr == REG_AW'(RA_THR))      reg_rdata = CNT_W'(st_q.thr);
        else if (reg_addr == REG_AW'(RA_PSIZE))    reg_rdata = CNT_W'(st_q.psize);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gpm_checker.sv
module gpm_checker
    import gpm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int REG_AW = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_we,
    input logic [REG_AW-1:0]             reg_addr,
    input logic                          wr_valid,
    input logic                          wr_ready,
    input logic                          en,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
    logic cfg_clear, cfg_preset;
    assign cfg_clear  = reg_we && (reg_addr == REG_AW'(RA_CLEAR));
    assign cfg_preset = reg_we && (reg_addr == REG_AW'(RA_PRESET));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> (cnt == '0));

    a_r9_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_preset |=> (cnt[0] == '0) && (cnt[NUM_CNT-1] == CNT_W'(4 * (NUM_CNT - 1))));

    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reg_we) |=> $stable(cnt));

    a_r2_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !reg_we && wr_valid && wr_ready) |=> (cnt[CI_WR_DONE] == $past(cnt[CI_WR_DONE]) + CNT_W'(1)));

    a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !reg_we) |=> (CNT_W'(cnt[CI_WR_HIT] - $past(cnt[CI_WR_HIT])) <= CNT_W'(1)));

    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !reg_we) |=> (CNT_W'(cnt[CI_PAGE] - $past(cnt[CI_PAGE])) <= CNT_W'(2)));
endmodule

bind gfx_page_monitor gpm_checker #(.CNT_W(CNT_W), .REG_AW(REG_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .en       (en_q),
    .cnt      (cnt_q)
);

// File: tb/tb_gfx_page_monitor.sv
`timescale 1ns/100ps
module tb_gfx_page_monitor;
    localparam int CNT_W = 32, ADDR_W = 32, THR_W = 8, REG_AW = 4, NC = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rq_valid = 0, rq_ready = 0, rd_valid = 0, rd_ready = 0, wr_valid = 0, wr_ready = 0;
    logic [ADDR_W-1:0] rq_addr = '0, wr_addr = '0;
    logic reg_we = 0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [CNT_W-1:0] reg_wdata = '0, reg_rdata;

    always #10 clk = ~clk;

    gfx_page_monitor #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .THR_W(THR_W), .REG_AW(REG_AW)) dut (
        .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata));

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_cnt [NC];
    logic        m_en;
    logic [7:0]  m_thr;
    logic [1:0]  m_ps;
    logic [8:0]  m_run [3];
    logic [31:0] m_last;
    logic        m_lv;

    function automatic string req_of(int i);
        if (i <= 1) return "R2";
        if (i <= 4) return "R3";
        if (i <= 7) return "R4";
        return "R5";
    endfunction

    function automatic logic [31:0] page_of(logic [31:0] a, logic [1:0] ps);
        return a >> (11 + ps);
    endfunction

    task automatic chk(string rq, string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s (%s) got=%0h exp=%0h t=%0t", rq, tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NC; i++) m_cnt[i] = 0;
        for (int k = 0; k < 3; k++) m_run[k] = 0;
        m_en = 0; m_thr = 0; m_ps = 0; m_last = 0; m_lv = 0;
    endtask

    task automatic model_step();
        logic [2:0] busy, hit;
        logic rf, wf, clr, pre;
        logic [31:0] rp, wp;
        int pinc;
        busy = {wr_valid & ~wr_ready, rd_valid & ~rd_ready, rq_valid & ~rq_ready};
        for (int k = 0; k < 3; k++) hit[k] = busy[k] && (m_run[k] == {1'b0, m_thr});
        rf = rq_valid & rq_ready; wf = wr_valid & wr_ready;
        clr = reg_we && reg_addr == 4'd12; pre = reg_we && reg_addr == 4'd13;
        rp = page_of(rq_addr, m_ps); wp = page_of(wr_addr, m_ps);
        pinc = 0;
        if (clr) m_lv = 0;
        else begin
            if (rf) begin if (m_lv && rp != m_last) pinc++; m_last = rp; m_lv = 1; end
            if (wf) begin if (m_lv && wp != m_last) pinc++; m_last = wp; m_lv = 1; end
        end
        if (clr) for (int i = 0; i < NC; i++) m_cnt[i] = 0;
        else if (pre) for (int i = 0; i < NC; i++) m_cnt[i] = 4 * i;
        else if (m_en) begin
            m_cnt[0] += 32'(wf);      m_cnt[1] += 32'(rf);
            m_cnt[2] += 32'(busy[2]); m_cnt[3] += 32'(busy[0]); m_cnt[4] += 32'(busy[1]);
            m_cnt[5] += 32'(hit[0]);  m_cnt[6] += 32'(hit[1]);  m_cnt[7] += 32'(hit[2]);
            m_cnt[8] += 32'(pinc);
        end
        for (int k = 0; k < 3; k++)
            m_run[k] = !busy[k] ? 9'd0 : (m_run[k] == 9'h1FF ? m_run[k] : m_run[k] + 9'd1);
        if (reg_we) begin
            if (reg_addr == 4'd9)  m_en  = reg_wdata[0];
            if (reg_addr == 4'd10) m_thr = reg_wdata[7:0];
            if (reg_addr == 4'd11) m_ps  = reg_wdata[1:0];
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < NC; i++) begin
            reg_addr = 4'(i); #0.5;
            chk(req_of(i), tag, reg_rdata, m_cnt[i]);
        end
        reg_addr = 4'd9;  #0.5; chk("R7",  tag, reg_rdata, 32'(m_en));
        reg_addr = 4'd10; #0.5; chk("R10", tag, reg_rdata, 32'(m_thr));
        reg_addr = 4'd11; #0.5; chk("R10", tag, reg_rdata, 32'(m_ps));
    endtask

    task automatic cyc(string tag, logic rqv, logic rqr, logic [31:0] ra, logic rdv, logic rdr,
                       logic wv, logic wr, logic [31:0] wa, logic we, logic [3:0] a, logic [31:0] wd);
        @(negedge clk);
        rq_valid = rqv; rq_ready = rqr; rq_addr = ra; rd_valid = rdv; rd_ready = rdr;
        wr_valid = wv; wr_ready = wr; wr_addr = wa; reg_we = we; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        model_step();
        #2;
        check_all(tag);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr_reg(string tag, logic [3:0] a, logic [31:0] d);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, a, d);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        // R1 reset state, R10 command registers read 0
        #2 check_all("R1");
        reg_addr = 4'd12; #0.5; chk("R10", "R1", reg_rdata, 0);
        reg_addr = 4'd13; #0.5; chk("R10", "R1", reg_rdata, 0);

        // R7 disabled: traffic leaves counters at 0
        cyc("R7", 1, 1, 32'h100, 1, 0, 1, 0, 32'h900, 0, 0, 0);
        cyc("R7", 1, 0, 32'h100, 1, 1, 1, 1, 32'h900, 0, 0, 0);
        wr_reg("R8", 4'd12, 0);
        wr_reg("R7", 4'd9, 1);
        wr_reg("R4", 4'd10, 2);

        // R4 write stall of exactly 2 cycles then 3 cycles
        cyc("R4", 0, 0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 0);
        cyc("R4", 0, 0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 0);
        cyc("R4", 0, 0, 0, 0, 0, 1, 1, 32'h0, 0, 0, 0);
        repeat (3) cyc("R4", 0, 0, 0, 1, 0, 1, 0, 32'h0, 0, 0, 0);
        cyc("R4", 1, 0, 0, 1, 1, 1, 1, 32'h0, 0, 0, 0);

        // R5 page size 2K and 4K boundaries
        wr_reg("R8", 4'd12, 0);
        cyc("R6", 1, 1, 32'h7FC, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5", 1, 1, 32'h800, 0, 0, 0, 0, 0, 0, 0, 0);
        wr_reg("R5", 4'd11, 1);
        cyc("R5", 0, 0, 0, 0, 0, 1, 1, 32'hFFC, 0, 0, 0);
        cyc("R5", 1, 1, 32'h1000, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6 same-cycle read and write on two further pages
        cyc("R6", 1, 1, 32'h2000, 0, 0, 1, 1, 32'h3000, 0, 0, 0);
        // R8 clear with traffic in the same cycle, then counting resumes
        cyc("R8", 1, 1, 32'h5000, 1, 0, 1, 0, 0, 1, 4'd12, 0);
        cyc("R8", 1, 1, 32'h9000, 0, 0, 1, 1, 32'h9004, 0, 0, 0);
        // R9 preset with traffic in the same cycle
        cyc("R9", 1, 1, 32'h0, 1, 0, 1, 0, 0, 1, 4'd13, 0);
        idle("R9");

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic we;
            logic [3:0] a;
            logic [31:0] d;
            we = ($urandom % 16) == 0;
            case ($urandom % 6)
                0: a = 4'd9;  1: a = 4'd10; 2: a = 4'd11;
                3: a = 4'd12; 4: a = 4'd13; default: a = 4'd9;
            endcase
            d = $urandom;
            if (a == 4'd9) d[0] = ($urandom % 4) != 0;
            if (a == 4'd10) d = d % 5;
            cyc("R6", 1'($urandom), 1'($urandom), $urandom & 32'h0000_7FFC,
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                $urandom & 32'h0000_7FFC, we, a, d);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule